// File: doc/BRIEF.md
# Cache Miss Rate Monitor

This block sits next to a cache controller and measures how well the cache is doing. It receives one-cycle hit and miss strobes from the controller and counts them in two saturating counters while a run bit is set. A programmable observation window, timed by a reference-tick enable that models a slower reference clock, can end a measurement on its own. When the window runs out, the run bit drops by itself and the counts freeze for software to read.

A second trigger watches the miss counter against a programmable limit. Either trigger sets its own sticky status flag and, if the interrupt enable is set, sends a single-cycle interrupt pulse. A zero window length or a zero limit turns the matching trigger off. Software reaches everything through a small word-addressed register port: a write strobe with address and data, and read data that is registered one cycle after the address is presented.

Top module: `miss_rate_monitor`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: While the run bit (control bit 0) is 0, the hit and miss counts hold, reference ticks have no effect, and the window counter reloads from the window-length register (address 3).
- R3: While the run bit is 1, each cycle with `hit_i` high adds one to the hit count (address 1) and each cycle with `miss_i` high adds one to the miss count (address 2).
- R4: With a nonzero window length N, after the N-th reference tick seen while running, the hardware clears the run bit and sets the window flag (control bit 2), both visible on the next read.
- R5: A window length of 0 never ends the run and never sets the window flag.
- R6: When a counted miss makes the miss count equal to the nonzero limit (address 4), the limit flag (control bit 3) sets and one interrupt cause is raised; it is not raised again while the count stays at or above the limit.
- R7: A limit of 0 never sets the limit flag and never raises an interrupt.
- R8: `irq_o` is a one-cycle pulse, high in the cycle after the triggering clock edge, and only when the interrupt enable (control bit 1) is 1; the flags set regardless of the enable.
- R9: Writing 0 to a flag bit in the control register clears it; writing 1 leaves it unchanged.
- R10: Software can write and read back the hit count, miss count, window length and limit; read data appears one cycle after the address, and unused addresses read 0.
- R11: The hit count (19 bits) and miss count (18 bits) stop at their all-ones value instead of wrapping.
- R12: A strobe in the same cycle as the window expiry is counted; strobes after the automatic stop are not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 1 | One-cycle cache hit strobe |
| miss_i | input | 1 | One-cycle cache miss strobe |
| ref_tick_i | input | 1 | Reference-time tick enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (3) | Register word address |
| reg_wdata | input | DATA_W (19) | Register write data |
| reg_rdata | output | DATA_W (19) | Registered read data |
| irq_o | output | 1 | Interrupt pulse |

## Verification
Random hit, miss and tick streams with both triggers off show that counting follows the strobes exactly and that ticks alone cannot stop a zero-length window. Directed windows with sparse ticks and a continuous hit stream tell apart an expiry that is off by one tick and a run bit that drops one cycle early or late, since either changes the frozen hit total. Back-to-back misses across the limit separate a level-type from an edge-type limit trigger, and the same stream with the enable cleared or the limit at zero separates flag setting from pulse gating. Preloaded counts near the top separate saturation from wrap.

// File: rtl/mrm_pkg.sv
package mrm_pkg;
  localparam int A_CTRL   = 0;
  localparam int A_HITS   = 1;
  localparam int A_MISSES = 2;
  localparam int A_WINDOW = 3;
  localparam int A_LIMIT  = 4;

  localparam int B_RUN    = 0;
  localparam int B_IRQEN  = 1;
  localparam int B_WFLAG  = 2;
  localparam int B_LFLAG  = 3;
endpackage

// File: rtl/mrm_sat_cnt.sv
module mrm_sat_cnt #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load_en) begin
      q <= load_val;
    end else if (inc && (q != MAXV)) begin
      q <= q + 1'b1;
    end
  end
endmodule

// File: rtl/mrm_window_timer.sv
module mrm_window_timer #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] length,
  output logic         expire
);
  logic [W-1:0] remain;

  assign expire = run && tick && (remain == W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (!run) begin
      remain <= length;
    end else if (tick && (remain != '0)) begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/mrm_irq_gen.sv
module mrm_irq_gen (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic win_evt,
  input  logic lim_evt,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= enable && (win_evt || lim_evt);
    end
  end
endmodule

// File: rtl/miss_rate_monitor.sv
module miss_rate_monitor #(
  parameter int HIT_W  = 19,
  parameter int MISS_W = 18,
  parameter int WIN_W  = 18,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_i,
  input  logic              miss_i,
  input  logic              ref_tick_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  import mrm_pkg::*;

  logic              run_q;
  logic              irq_en_q;
  logic              win_flag_q;
  logic              lim_flag_q;
  logic [WIN_W-1:0]  win_len_q;
  logic [MISS_W-1:0] limit_q;
  logic [HIT_W-1:0]  hit_cnt;
  logic [MISS_W-1:0] miss_cnt;

  logic wr_ctrl, wr_hits, wr_miss, wr_win, wr_lim;
  logic win_evt, lim_evt;
  logic [MISS_W:0] miss_plus;

  assign wr_ctrl = reg_we && (reg_addr == ADDR_W'(A_CTRL));
  assign wr_hits = reg_we && (reg_addr == ADDR_W'(A_HITS));
  assign wr_miss = reg_we && (reg_addr == ADDR_W'(A_MISSES));
  assign wr_win  = reg_we && (reg_addr == ADDR_W'(A_WINDOW));
  assign wr_lim  = reg_we && (reg_addr == ADDR_W'(A_LIMIT));

  mrm_sat_cnt #(.W(HIT_W)) u_hits (
    .clk      (clk),
    .rst      (rst),
    .load_en  (wr_hits),
    .load_val (reg_wdata[HIT_W-1:0]),
    .inc      (run_q && hit_i),
    .q        (hit_cnt)
  );

  mrm_sat_cnt #(.W(MISS_W)) u_misses (
    .clk      (clk),
    .rst      (rst),
    .load_en  (wr_miss),
    .load_val (reg_wdata[MISS_W-1:0]),
    .inc      (run_q && miss_i),
    .q        (miss_cnt)
  );

  mrm_window_timer #(.W(WIN_W)) u_window (
    .clk    (clk),
    .rst    (rst),
    .run    (run_q),
    .tick   (ref_tick_i),
    .length (win_len_q),
    .expire (win_evt)
  );

  assign miss_plus = {1'b0, miss_cnt} + 1'b1;
  assign lim_evt   = run_q && miss_i && !wr_miss && (limit_q != '0) &&
                     (miss_plus == {1'b0, limit_q});

  mrm_irq_gen u_irq (
    .clk     (clk),
    .rst     (rst),
    .enable  (irq_en_q),
    .win_evt (win_evt),
    .lim_evt (lim_evt),
    .irq     (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= 1'b0;
      irq_en_q   <= 1'b0;
      win_flag_q <= 1'b0;
      lim_flag_q <= 1'b0;
      win_len_q  <= '0;
      limit_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q      <= reg_wdata[B_RUN];
        irq_en_q   <= reg_wdata[B_IRQEN];
        win_flag_q <= win_flag_q && reg_wdata[B_WFLAG];
        lim_flag_q <= lim_flag_q && reg_wdata[B_LFLAG];
      end
      if (wr_win) win_len_q <= reg_wdata[WIN_W-1:0];
      if (wr_lim) limit_q   <= reg_wdata[MISS_W-1:0];
      if (win_evt) begin
        run_q      <= 1'b0;
        win_flag_q <= 1'b1;
      end
      if (lim_evt) lim_flag_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (int'(reg_addr))
        A_CTRL:   reg_rdata <= DATA_W'({lim_flag_q, win_flag_q, irq_en_q, run_q});
        A_HITS:   reg_rdata <= DATA_W'(hit_cnt);
        A_MISSES: reg_rdata <= DATA_W'(miss_cnt);
        A_WINDOW: reg_rdata <= DATA_W'(win_len_q);
        A_LIMIT:  reg_rdata <= DATA_W'(limit_q);
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mrm_checker.sv
module mrm_checker #(
  parameter int HIT_W  = 19,
  parameter int MISS_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              hit_i,
  input logic              miss_i,
  input logic              wr_hits,
  input logic              wr_miss,
  input logic              run_q,
  input logic              irq_en_q,
  input logic              win_flag_q,
  input logic [HIT_W-1:0]  hit_cnt,
  input logic [MISS_W-1:0] miss_cnt,
  input logic              irq_o
);
  localparam logic [HIT_W-1:0]  HMAX = {HIT_W{1'b1}};
  localparam logic [MISS_W-1:0] MMAX = {MISS_W{1'b1}};

  assert_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wr_hits && !wr_miss) |=> ($stable(hit_cnt) && $stable(miss_cnt)));

  assert_hit_step_R3: assert property (@(posedge clk) disable iff (rst)
    (run_q && hit_i && !wr_hits && hit_cnt != HMAX) |=> (hit_cnt == $past(hit_cnt) + 1'b1));

  assert_stop_on_expiry_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(win_flag_q) |-> !run_q);

  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  assert_pulse_gated_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(irq_en_q));

  assert_hit_saturate_R11: assert property (@(posedge clk) disable iff (rst)
    (hit_cnt == HMAX && !wr_hits) |=> (hit_cnt == HMAX));

  assert_miss_saturate_R11: assert property (@(posedge clk) disable iff (rst)
    (miss_cnt == MMAX && !wr_miss) |=> (miss_cnt == MMAX));
endmodule

bind miss_rate_monitor mrm_checker #(.HIT_W(HIT_W), .MISS_W(MISS_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hit_i      (hit_i),
  .miss_i     (miss_i),
  .wr_hits    (wr_hits),
  .wr_miss    (wr_miss),
  .run_q      (run_q),
  .irq_en_q   (irq_en_q),
  .win_flag_q (win_flag_q),
  .hit_cnt    (hit_cnt),
  .miss_cnt   (miss_cnt),
  .irq_o      (irq_o)
);

// File: tb/miss_rate_monitor_test.sv
`timescale 1ns/1ps
module miss_rate_monitor_test;
  localparam int HIT_W = 19;
  localparam int MISS_W = 18;
  localparam int DW = 19;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hit = 1'b0, miss = 1'b0, tick = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  miss_rate_monitor uut (
    .clk(clk), .rst(rst), .hit_i(hit), .miss_i(miss), .ref_tick_i(tick),
    .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  function automatic int sat_add(int v, int n, int w);
    int m = (1 << w) - 1;
    return (v + n > m) ? m : v + n;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    we = 1'b1; addr = 3'(a); wdata = DW'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    addr = 3'(a);
    @(negedge clk);
    d = int'(rdata);
  endtask

  task automatic miss_burst(int n, output int pulses, output int first_idx);
    pulses = 0; first_idx = -1;
    for (int i = 0; i < n + 4; i++) begin
      @(negedge clk);
      if (irq) begin pulses++; if (first_idx < 0) first_idx = i; end
      miss = (i < n);
    end
    miss = 1'b0;
  endtask

  initial begin
    int v, eh, em, pulses, first, ticks, hits_at, prev_irq;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", int'(irq), 0);
    for (int a = 0; a < 5; a++) begin rd(a, v); check("R1 reg", v, 0); end

    // R2 counts frozen while stopped
    for (int i = 0; i < 6; i++) begin @(negedge clk); hit = 1; miss = 1; tick = 1; end
    @(negedge clk); hit = 0; miss = 0; tick = 0;
    rd(1, v); check("R2 hits", v, 0);
    rd(2, v); check("R2 misses", v, 0);

    // R3/R5 random strobes, window length 0, limit 0
    wr(0, 3);
    eh = 0; em = 0; pulses = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (irq) pulses++;
      hit = 1'($urandom); miss = ($urandom % 4) == 0; tick = 1'($urandom);
      if (hit) eh++;
      if (miss) em++;
    end
    @(negedge clk); hit = 0; miss = 0; tick = 0;
    check("R7 no irq with limit 0", pulses, 0);
    rd(0, v); check("R5 run still set, no flag", v, 3);
    wr(0, 2);
    rd(1, v); check("R3 hits", v, eh);
    rd(2, v); check("R3 misses", v, em);
    rd(0, v); check("R7 no limit flag", v, 2);

    // R4/R8/R12 window of 5 ticks, tick every 3rd cycle, hits every cycle
    wr(1, 0); wr(3, 5); wr(0, 3);
    ticks = 0; hits_at = -1; pulses = 0; first = -1; prev_irq = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (irq) begin
        pulses++;
        if (first < 0) begin first = i; check("R4 ticks before expiry", ticks, 5); end
      end
      if (prev_irq && irq) check("R8 pulse width", 1, 0);
      prev_irq = int'(irq);
      hit = 1'b1;
      tick = (i % 3) == 2;
      if (tick) begin ticks++; if (ticks == 5) hits_at = i + 1; end
    end
    @(negedge clk); hit = 0; tick = 0;
    check("R8 one pulse", pulses, 1);
    rd(1, v); check("R12 hits frozen incl expiry cycle", v, hits_at);
    rd(0, v); check("R4 run cleared, window flag", v, 6);

    // R9 flag clear semantics
    wr(0, 6); rd(0, v); check("R9 write 1 keeps flag", v, 6);
    wr(0, 2); rd(0, v); check("R9 write 0 clears flag", v, 2);
    rd(3, v); check("R10 window readback", v, 5);

    // R6 limit 4, eight misses back to back
    wr(3, 0); wr(2, 0); wr(4, 4); wr(0, 3);
    miss_burst(8, pulses, first);
    check("R6 single pulse", pulses, 1);
    check("R8 pulse cycle", first, 4);
    rd(0, v); check("R6 limit flag", v, 11);
    rd(2, v); check("R6 misses", v, 8);

    // R8 enable off: flag sets, no pulse
    wr(0, 0); wr(2, 0); wr(0, 1);
    miss_burst(6, pulses, first);
    check("R8 masked no pulse", pulses, 0);
    rd(0, v); check("R8 flag without enable", v, 9);

    // R7 limit 0
    wr(0, 0); wr(2, 0); wr(4, 0); wr(0, 3);
    miss_burst(6, pulses, first);
    check("R7 limit 0 no pulse", pulses, 0);
    rd(0, v); check("R7 limit 0 no flag", v, 3);

    // R10/R11 preload and saturation
    wr(0, 0);
    wr(1, (1 << HIT_W) - 3); rd(1, v); check("R10 hits preload", v, (1 << HIT_W) - 3);
    wr(2, (1 << MISS_W) - 2);
    wr(0, 1);
    for (int i = 0; i < 5; i++) begin @(negedge clk); hit = 1; miss = 1; end
    @(negedge clk); hit = 0; miss = 0;
    wr(0, 0);
    rd(1, v); check("R11 hit saturate", v, sat_add((1 << HIT_W) - 3, 5, HIT_W));
    rd(2, v); check("R11 miss saturate", v, sat_add((1 << MISS_W) - 2, 5, MISS_W));
    rd(7, v); check("R10 unused address", v, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule